// File: doc/BRIEF.md
# Four-PPM Infrared Frame Receiver with Station Address Filter

This receiver takes infrared chip slots that have already been sampled and aligned to symbol boundaries. They arrive as one four-slot symbol per valid cycle. While idle it watches for the eight-symbol opening flag. It then decodes each single-pulse symbol into a two-bit pair and packs four pairs into a byte. It ends the frame on the eight-symbol closing flag. The opening and closing flags are made of symbols with no pulse or two pulses, which can never carry data.

The last four bytes of every frame are a CRC-32 and are never forwarded. All earlier bytes go out in arrival order on a byte stream, including the leading address byte and any control byte. When the frame closes, a one-cycle end pulse reports the frame, and a CRC-error flag is raised alongside it if the check fails. A frame that is malformed is terminated with an abort pulse instead. With filtering enabled, a frame whose first byte is neither the programmed station address nor the broadcast value 0xFF is dropped silently.

Top module: `ppm4_frame_rx`

## Requirements
- R1: A symbol is `chip[3:0]`, where `chip[3]` is the earliest slot. A single pulse encodes a pair: `1000`=0, `0100`=1, `0010`=2, `0001`=3. The first pair of a byte is its bits [1:0], and the fourth pair is bits [7:6].
- R2: Before a frame begins, no symbol sequence produces any output, including preamble chips and partial flags. The eight symbols `0000 1100 0000 1100 0110 0000 0110 0000` (hex 0C0C6060, first symbol leftmost) open a frame.
- R3: Every decoded byte of the frame except the last four is emitted in order, the address byte first. Each byte appears on `out_data` with a one-cycle `out_valid`, in the cycle after the symbol that completes the byte following it by four bytes.
- R4: A CRC-32 is computed over the emitted bytes. It uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. The result must equal the last four bytes, with the first of those bytes as the least significant. On a mismatch, `crc_err` is high in the same cycle as `frame_end`.
- R5: The symbols `0000 1100 0000 1100 0000 0110 0000 0110` (hex 0C0C0606) close the frame. `frame_end` pulses in the cycle after the final closing symbol is accepted.
- R6: If the closing flag arrives while a byte is partly assembled, `frame_abort` pulses in place of `frame_end`.
- R7: Inside a frame, any symbol that is neither a single-pulse symbol nor the next expected closing-flag symbol makes `frame_abort` pulse. The receiver then returns to searching for an opening flag.
- R8: A frame that closes after fewer than four whole bytes raises `frame_abort`.
- R9: When `addr_match_en` is high and the first byte is neither `station_addr` nor 0xFF, the frame produces no byte, no end and no abort. The receiver then searches for the next opening flag.
- R10: The station's own address and the broadcast address 0xFF are accepted when filtering is on. Any address is accepted when `addr_match_en` is low.
- R11: The payload length has no limit, so a frame of dozens of bytes is delivered in full.
- R12: After reset, and in any cycle following one without `chip_valid`, `out_valid`, `frame_end`, `crc_err` and `frame_abort` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_valid | input | 1 | A symbol is present on `chip` |
| chip | input | 4 | Four slots of one symbol, bit 3 earliest |
| addr_match_en | input | 1 | Enables the station address filter |
| station_addr | input | 8 | This station's receive address |
| out_valid | output | 1 | `out_data` holds a frame byte |
| out_data | output | 8 | Decoded frame byte |
| frame_end | output | 1 | Frame closed cleanly |
| crc_err | output | 1 | CRC mismatch, valid with `frame_end` |
| frame_abort | output | 1 | Frame terminated as malformed |

## Verification
The CRC verdict and the end of frame share one output cycle. The bench provokes this by flipping a bit in one CRC byte of an otherwise good frame. It then expects a single scoreboard item that carries both flags, after the payload bytes have matched in order. The residue abort falls in the same cycle where an end would otherwise appear. Two stray pair symbols are placed before the closing flag, and the bench expects an abort item in place of the end item.

// File: rtl/ppm4_frame_rx.sv
module ppm4_frame_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_valid,
  input  logic [3:0] chip,
  input  logic       addr_match_en,
  input  logic [7:0] station_addr,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       frame_end,
  output logic       crc_err,
  output logic       frame_abort
);

  localparam logic [31:0] OPEN_FLAG  = 32'h0C0C_6060;
  localparam logic [31:0] CLOSE_FLAG = 32'h0C0C_0606;
  localparam logic [31:0] CRC_POLY   = 32'hEDB8_8320;

  typedef enum logic {HUNT, BODY} st_t;

  st_t         st;
  logic [31:0] hunt_sr, hold, crc;
  logic [7:0]  shreg;
  logic [2:0]  stop_idx, nbytes;
  logic [1:0]  pair_cnt;
  logic        first;

  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++)
      c = (c[0] ^ b[i]) ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    return c;
  endfunction

  logic [1:0]  pair;
  always_comb
    case (chip)
      4'b0100: pair = 2'd1;
      4'b0010: pair = 2'd2;
      4'b0001: pair = 2'd3;
      default: pair = 2'd0;
    endcase

  wire        single    = $onehot(chip);
  wire [7:0]  nb        = {pair, shreg[7:2]};
  wire [31:0] hunt_next = {hunt_sr[27:0], chip};
  wire [4:0]  stop_ofs  = {3'd7 - stop_idx, 2'b00};
  wire [3:0]  stop_sym  = CLOSE_FLAG[stop_ofs +: 4];
  wire        reject    = first && addr_match_en && nb != station_addr && nb != 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= HUNT;
      hunt_sr <= '0;
      hold <= '0;
      crc <= '1;
      shreg <= '0;
      stop_idx <= '0;
      nbytes <= '0;
      pair_cnt <= '0;
      first <= 1'b0;
      out_valid <= 1'b0;
      out_data <= '0;
      frame_end <= 1'b0;
      crc_err <= 1'b0;
      frame_abort <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      frame_end <= 1'b0;
      crc_err <= 1'b0;
      frame_abort <= 1'b0;
      if (chip_valid) begin
        if (st == HUNT) begin
          if (hunt_next == OPEN_FLAG) begin
            st <= BODY;
            hunt_sr <= '0;
            stop_idx <= '0;
            pair_cnt <= '0;
            nbytes <= '0;
            crc <= '1;
            first <= 1'b1;
          end else begin
            hunt_sr <= hunt_next;
          end
        end else if (stop_idx == 3'd0 && single) begin
          shreg <= nb;
          pair_cnt <= pair_cnt + 2'd1;
          if (pair_cnt == 2'd3) begin
            first <= 1'b0;
            if (reject) begin
              st <= HUNT;
            end else begin
              hold <= {nb, hold[31:8]};
              if (nbytes == 3'd4) begin
                out_valid <= 1'b1;
                out_data <= hold[7:0];
                crc <= crc_step(crc, hold[7:0]);
              end else begin
                nbytes <= nbytes + 3'd1;
              end
            end
          end
        end else if (chip == stop_sym) begin
          if (stop_idx == 3'd7) begin
            st <= HUNT;
            if (pair_cnt != 2'd0 || nbytes != 3'd4) begin
              frame_abort <= 1'b1;
            end else begin
              frame_end <= 1'b1;
              crc_err <= (~crc != hold);
            end
          end else begin
            stop_idx <= stop_idx + 3'd1;
          end
        end else begin
          st <= HUNT;
          frame_abort <= 1'b1;
        end
      end
    end
  end

  AST_QUIET_WITHOUT_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid |=> !(out_valid || frame_end || crc_err || frame_abort)); // R12
  AST_CRC_ERR_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> frame_end); // R4
  AST_END_EXCLUDES_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_end && frame_abort)); // R6
  AST_HUNT_EMITS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HUNT) |=> !out_valid); // R2
  AST_TERMINATION_RETURNS_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end || frame_abort) |-> (st == HUNT)); // R7

endmodule

// File: tb/ppm4_frame_rx_test.sv
module ppm4_frame_rx_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_valid = 1'b0;
  logic [3:0] chip = '0;
  logic       addr_match_en = 1'b0;
  logic [7:0] station_addr = '0;
  logic       out_valid, frame_end, crc_err, frame_abort;
  logic [7:0] out_data;

  ppm4_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .chip_valid(chip_valid), .chip(chip),
    .addr_match_en(addr_match_en), .station_addr(station_addr),
    .out_valid(out_valid), .out_data(out_data), .frame_end(frame_end),
    .crc_err(crc_err), .frame_abort(frame_abort));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int qk[$];
  int qd[$];
  string qt[$];
  logic [7:0] fb[$];

  localparam int K_BYTE = 0, K_END = 1, K_END_ERR = 2, K_ABORT = 3;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_item(int k, int d, string tag);
    qk.push_back(k);
    qd.push_back(d);
    qt.push_back(tag);
  endtask

  task automatic take(int k, int d);
    if (qk.size() == 0) begin
      check("R9/R12 unexpected output", k * 256 + d, -1);
    end else begin
      int ek = qk.pop_front();
      int ed = qd.pop_front();
      string t = qt.pop_front();
      check(t, k * 256 + d, ek * 256 + ed);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (out_valid) take(K_BYTE, int'(out_data));
      if (frame_end) take(crc_err ? K_END_ERR : K_END, 0);
      if (frame_abort) take(K_ABORT, 0);
    end
  end

  task automatic sym(logic [3:0] s);
    chip_valid = 1'b1;
    chip = s;
    @(negedge clk);
    chip_valid = 1'b0;
    chip = '0;
  endtask

  task automatic word(logic [31:0] w);
    for (int i = 0; i < 8; i++) sym(w[31 - 4 * i -: 4]);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int k = 0; k < 4; k++) sym(4'b1000 >> b[2 * k +: 2]);
  endtask

  function automatic logic [31:0] crc32_of();
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (fb[i])
      for (int j = 0; j < 8; j++) begin
        logic fbit = c[0] ^ fb[i][j];
        c = c >> 1;
        if (fbit) c = c ^ 32'hEDB8_8320;
      end
    return ~c;
  endfunction

  task automatic run_frame(bit pass, bit bad_crc, int residue, string tag);
    logic [31:0] c = crc32_of();
    if (bad_crc) c = c ^ 32'h0010_0000;
    if (pass) begin
      foreach (fb[i]) expect_item(K_BYTE, int'(fb[i]), tag);
      if (residue > 0) expect_item(K_ABORT, 0, tag);
      else expect_item(bad_crc ? K_END_ERR : K_END, 0, tag);
    end
    for (int i = 0; i < 4; i++) word(32'h80A8_80A8);
    word(32'h0C0C_6060);
    foreach (fb[i]) send_byte(fb[i]);
    for (int i = 0; i < 4; i++) send_byte(c[8 * i +: 8]);
    for (int i = 0; i < residue; i++) sym(4'b0100);
    word(32'h0C0C_0606);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset idle", {out_valid, frame_end, crc_err, frame_abort}, 0);

    fb = '{8'h12, 8'hA5, 8'h00, 8'hFF, 8'h3C};
    run_frame(1, 0, 0, "R1/R3/R5/R10 filter off");

    sym(4'b0001); sym(4'b0010); sym(4'b0000); sym(4'b1100);
    sym(4'b0000); sym(4'b1100); sym(4'b1000); sym(4'b1111);
    fb = '{8'h77, 8'h1B, 8'hE4};
    run_frame(1, 0, 0, "R2 noise before open flag");

    addr_match_en = 1'b1;
    station_addr = 8'h34;
    fb = '{8'h34, 8'h01, 8'h02};
    run_frame(1, 0, 0, "R10 own address");
    fb = '{8'hFF, 8'h9E};
    run_frame(1, 0, 0, "R10 broadcast");
    fb = '{8'h35, 8'h55, 8'hAA};
    run_frame(0, 0, 0, "R9 rejected");
    check("R9 rejected frame silent", qk.size(), 0);
    fb = '{8'h34, 8'hC3};
    run_frame(1, 0, 0, "R9 next frame accepted");
    addr_match_en = 1'b0;

    fb = '{8'h40, 8'h10, 8'h20, 8'h30};
    run_frame(1, 1, 0, "R4 crc error with end");
    fb = '{8'h41, 8'h5A};
    run_frame(1, 0, 2, "R6 residue abort");

    expect_item(K_ABORT, 0, "R8 short frame");
    word(32'h0C0C_6060);
    send_byte(8'h11); send_byte(8'h22);
    word(32'h0C0C_0606);
    repeat (3) @(negedge clk);

    expect_item(K_ABORT, 0, "R7 invalid symbol");
    word(32'h0C0C_6060);
    send_byte(8'h11); send_byte(8'h22);
    sym(4'b1111);
    repeat (3) @(negedge clk);

    expect_item(K_BYTE, 8'h61, "R7 stop mismatch");
    expect_item(K_BYTE, 8'h62, "R7 stop mismatch");
    expect_item(K_ABORT, 0, "R7 stop mismatch");
    word(32'h0C0C_6060);
    for (int i = 1; i <= 6; i++) send_byte(8'h60 + 8'(i));
    sym(4'b0000); sym(4'b1100); sym(4'b0000); sym(4'b0001);
    repeat (3) @(negedge clk);

    fb = '{8'h01, 8'h20};
    run_frame(1, 0, 0, "R7 recovery after abort");

    fb.delete();
    for (int i = 0; i < 40; i++) fb.push_back(8'(i * 37 + 5));
    run_frame(1, 0, 0, "R11 long frame");

    repeat (5) @(negedge clk);
    check("R3 all expected items seen", qk.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule